// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This engine takes frames arriving one byte per cycle on a stream input and stores each frame in host memory through a ring of sixteen receive descriptors. When a frame starts, the engine reads descriptor status bytes, beginning at its current ring index, until it finds one that the host has handed over. It then writes the frame bytes into that entry's buffer. Short frames are padded with zeros and long frames are cut off at the end of the buffer. The engine writes the stored byte count into the descriptor's message-length word. It then returns the descriptor to the host by rewriting its status byte, and pulses a completion strobe to the control/status block.

The stream input stalls through `rxReady` while the engine searches the ring. When the controller is stopped, frames are taken in and thrown away. When no entry is available, frames are also taken in and thrown away, and a one-cycle missed-frame strobe is raised. Each 8-byte descriptor has this layout: a 16-bit buffer address low word at +0, the status byte at +2, the high address byte at +3, a 16-bit negative buffer length at +4 and a 16-bit message length at +6. The engine uses only the status byte and the message length. Buffers sit in a separate array of fixed-size slots, with one slot for each ring entry.

Top module: `rxring_top`

## Requirements
- R1: After reset `rxReady`, `rxDone`, `rxMiss` and `rxIrq` are low and the ring index is 0.
- R2: Descriptor i starts at `ringBase + 8*i`. Its status byte is at +2 and its message length is at +6 (low byte) and +7 (high byte). The buffer of entry i starts at `bufBase + i*BUF_BYTES`.
- R3: The search starts at the current index and reads status bytes in ring order, wrapping modulo 16. An entry is taken only when its status byte is exactly 0x80. Skipped entries are not written, and no memory read happens while `rxReady` is high.
- R4: Frame bytes are written in arrival order to consecutive buffer addresses. The message length equals the number of bytes stored.
- R5: A frame shorter than 60 bytes is padded with zero bytes up to 60, and its message length is 60.
- R6: A frame longer than `BUF_BYTES` keeps only its first `BUF_BYTES` bytes, with nothing written past the buffer. Its message length is `BUF_BYTES` and its status becomes 0x53 (error 0x40, overflow 0x10, start 0x02, end 0x01).
- R7: Otherwise the status byte becomes 0x03, which clears ownership and marks start and end of packet. It is written after the length. `rxDone` is high for exactly that one cycle, and the index moves to the next entry modulo 16.
- R8: `rxIrq` pulses together with `rxDone` only when `intEnable` is high.
- R9: While `stopped` is high, a frame is consumed without any memory access and without `rxDone`.
- R10: If none of the 16 entries holds 0x80, the frame is consumed and discarded. `rxMiss` pulses for one cycle, no write occurs, and the ring index is left as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stopped | input | 1 | Controller stopped; frames are discarded |
| intEnable | input | 1 | Interrupt enable from the control block |
| ringBase | input | AW | Byte address of descriptor 0 |
| bufBase | input | AW | Byte address of buffer 0 |
| rxValid | input | 1 | Stream byte valid |
| rxData | input | 8 | Stream byte |
| rxLast | input | 1 | Marks the final byte of a frame |
| rxReady | output | 1 | Engine accepts the stream byte this cycle |
| memEn | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | AW | Byte address |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid the cycle after a read request |
| rxDone | output | 1 | One-cycle frame-stored strobe |
| rxMiss | output | 1 | One-cycle missed-frame strobe |
| rxIrq | output | 1 | One-cycle interrupt request |

## Verification
A status read is requested in one cycle, and its data is compared in the next, so each probed entry costs two cycles before the first byte is taken. The closing status write happens at the clock edge that ends the `rxDone` cycle, and the two length writes happen in the two cycles just before it. Padding adds up to 60 cycles after the last byte. The bench samples every output on the falling edge. After each frame it waits a fixed margin longer than the worst pad-and-close sequence, and then compares memory contents and strobe counts. Strobes are counted on every falling edge, so a pulse that is doubled or missing shows up as a count error.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam logic [7:0] STAT_OWNED = 8'h80;
  localparam logic [7:0] STAT_DONE  = 8'h03;
  localparam logic [7:0] STAT_OVFL  = 8'h53;

  typedef enum logic [2:0] {
    MS_NONE, MS_STAT_RD, MS_DATA, MS_ZERO, MS_LEN_LO, MS_LEN_HI, MS_STAT_WR
  } memSel_t;

  typedef struct packed {
    logic    clrCnt;
    logic    incCnt;
    logic    setOvf;
    logic    incIdx;
    logic    clrProbe;
    logic    incProbe;
    memSel_t memSel;
  } dpCtl_t;
endpackage

// File: rtl/rxring_dp.sv
module rxring_dp
  import rxring_pkg::*;
#(
  parameter int AW          = 24,
  parameter int LOG_ENTRIES = 4,
  parameter int BUF_BYTES   = 1544,
  parameter int MIN_BYTES   = 60
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic [AW-1:0] ringBase,
  input  logic [AW-1:0] bufBase,
  input  logic [7:0]    rxData,
  output logic          memEn,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [7:0]    memWdata,
  output logic          cntLtMin,
  output logic          cntFull,
  output logic          lastProbe
);
  localparam int CW      = $clog2(BUF_BYTES + 1);
  localparam int ENTRIES = 1 << LOG_ENTRIES;

  logic [LOG_ENTRIES-1:0] idx, probes;
  logic [CW-1:0]          cnt;
  logic                   ovf;
  logic [AW-1:0]          descAddr, bufAddr;
  logic [15:0]            lenWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx    <= '0;
      probes <= '0;
      cnt    <= '0;
      ovf    <= 1'b0;
    end else begin
      if (ctl.incIdx)   idx <= idx + 1'b1;
      if (ctl.clrProbe) probes <= '0;
      else if (ctl.incProbe) probes <= probes + 1'b1;
      if (ctl.clrCnt) begin
        cnt <= '0;
        ovf <= 1'b0;
      end else begin
        if (ctl.incCnt) cnt <= cnt + 1'b1;
        if (ctl.setOvf) ovf <= 1'b1;
      end
    end
  end

  assign cntLtMin  = (32'(cnt) < MIN_BYTES);
  assign cntFull   = (32'(cnt) == BUF_BYTES);
  assign lastProbe = (32'(probes) == ENTRIES - 1);
  assign lenWord   = 16'(cnt);
  assign descAddr  = ringBase + (AW'(idx) << 3);
  assign bufAddr   = bufBase + AW'(idx) * AW'(BUF_BYTES) + AW'(cnt);

  always_comb begin
    memEn    = (ctl.memSel != MS_NONE);
    memWe    = memEn && (ctl.memSel != MS_STAT_RD);
    memAddr  = '0;
    memWdata = 8'h00;
    unique case (ctl.memSel)
      MS_STAT_RD: memAddr = descAddr + AW'(2);
      MS_DATA: begin
        memAddr  = bufAddr;
        memWdata = rxData;
      end
      MS_ZERO:    memAddr = bufAddr;
      MS_LEN_LO: begin
        memAddr  = descAddr + AW'(6);
        memWdata = lenWord[7:0];
      end
      MS_LEN_HI: begin
        memAddr  = descAddr + AW'(7);
        memWdata = lenWord[15:8];
      end
      MS_STAT_WR: begin
        memAddr  = descAddr + AW'(2);
        memWdata = ovf ? STAT_OVFL : STAT_DONE;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rxring_ctl.sv
module rxring_ctl
  import rxring_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stopped,
  input  logic       rxValid,
  input  logic       rxLast,
  input  logic [7:0] memRdata,
  input  logic       cntLtMin,
  input  logic       cntFull,
  input  logic       lastProbe,
  output dpCtl_t     ctl,
  output logic       rxReady,
  output logic       rxDone,
  output logic       rxMiss
);
  typedef enum logic [3:0] {
    S_IDLE, S_PROBE, S_CHECK, S_FILL, S_PAD, S_LENLO, S_LENHI, S_CLOSE, S_MISS, S_DISCARD
  } state_t;

  state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    ctl.memSel = MS_NONE;
    rxReady   = 1'b0;
    rxDone    = 1'b0;
    rxMiss    = 1'b0;
    unique case (state)
      S_IDLE: begin
        ctl.clrCnt   = 1'b1;
        ctl.clrProbe = 1'b1;
        if (rxValid) nextState = stopped ? S_DISCARD : S_PROBE;
      end
      S_PROBE: begin
        ctl.memSel = MS_STAT_RD;
        nextState  = S_CHECK;
      end
      S_CHECK: begin
        if (memRdata == STAT_OWNED) nextState = S_FILL;
        else begin
          ctl.incIdx = 1'b1;
          if (lastProbe) nextState = S_MISS;
          else begin
            ctl.incProbe = 1'b1;
            nextState    = S_PROBE;
          end
        end
      end
      S_FILL: begin
        rxReady = 1'b1;
        if (rxValid) begin
          if (cntFull) ctl.setOvf = 1'b1;
          else begin
            ctl.memSel = MS_DATA;
            ctl.incCnt = 1'b1;
          end
          if (rxLast) nextState = S_PAD;
        end
      end
      S_PAD: begin
        if (cntLtMin) begin
          ctl.memSel = MS_ZERO;
          ctl.incCnt = 1'b1;
        end else nextState = S_LENLO;
      end
      S_LENLO: begin
        ctl.memSel = MS_LEN_LO;
        nextState  = S_LENHI;
      end
      S_LENHI: begin
        ctl.memSel = MS_LEN_HI;
        nextState  = S_CLOSE;
      end
      S_CLOSE: begin
        ctl.memSel = MS_STAT_WR;
        ctl.incIdx = 1'b1;
        rxDone     = 1'b1;
        nextState  = S_IDLE;
      end
      S_MISS: begin
        rxMiss    = 1'b1;
        nextState = S_DISCARD;
      end
      S_DISCARD: begin
        rxReady = 1'b1;
        if (rxValid && rxLast) nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/rxring_top.sv
module rxring_top
  import rxring_pkg::*;
#(
  parameter int AW          = 24,
  parameter int LOG_ENTRIES = 4,
  parameter int BUF_BYTES   = 1544,
  parameter int MIN_BYTES   = 60
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          stopped,
  input  logic          intEnable,
  input  logic [AW-1:0] ringBase,
  input  logic [AW-1:0] bufBase,
  input  logic          rxValid,
  input  logic [7:0]    rxData,
  input  logic          rxLast,
  output logic          rxReady,
  output logic          memEn,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [7:0]    memWdata,
  input  logic [7:0]    memRdata,
  output logic          rxDone,
  output logic          rxMiss,
  output logic          rxIrq
);
  dpCtl_t ctl;
  logic   cntLtMin, cntFull, lastProbe;

  rxring_ctl u_ctl (
    .clk(clk), .rstN(rstN), .stopped(stopped), .rxValid(rxValid), .rxLast(rxLast),
    .memRdata(memRdata), .cntLtMin(cntLtMin), .cntFull(cntFull), .lastProbe(lastProbe),
    .ctl(ctl), .rxReady(rxReady), .rxDone(rxDone), .rxMiss(rxMiss)
  );

  rxring_dp #(
    .AW(AW), .LOG_ENTRIES(LOG_ENTRIES), .BUF_BYTES(BUF_BYTES), .MIN_BYTES(MIN_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ringBase(ringBase), .bufBase(bufBase),
    .rxData(rxData), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .cntLtMin(cntLtMin), .cntFull(cntFull), .lastProbe(lastProbe)
  );

  assign rxIrq = rxDone && intEnable;
endmodule

// File: rtl/rxring_chk.sv
module rxring_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rstN,
  input logic          stopped,
  input logic          rxReady,
  input logic          memEn,
  input logic          memWe,
  input logic [AW-1:0] memAddr,
  input logic [7:0]    memWdata,
  input logic          rxDone,
  input logic          rxMiss,
  input logic          rxIrq
);
  p_close_status_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |-> (memEn && memWe && !memWdata[7] && (memWdata[1:0] == 2'b11)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone);

  p_miss_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    rxMiss |=> !rxMiss);

  p_miss_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    rxMiss |-> (!rxDone && !memEn));

  p_no_read_accepting_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWe) |-> !rxReady);

  p_irq_with_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);
endmodule

bind rxring_top rxring_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .stopped(stopped), .rxReady(rxReady), .memEn(memEn),
  .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .rxDone(rxDone),
  .rxMiss(rxMiss), .rxIrq(rxIrq)
);

// File: tb/sim_rxring_top.sv
module sim_rxring_top;
  localparam int AW   = 16;
  localparam int BUF  = 80;
  localparam int RING = 0;
  localparam int BUFB = 128;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopped = 1'b0, intEnable = 1'b1;
  logic rxValid = 1'b0, rxLast = 1'b0;
  logic [7:0] rxData = 8'h00;
  logic rxReady, memEn, memWe, rxDone, rxMiss, rxIrq;
  logic [AW-1:0] memAddr;
  logic [7:0] memWdata, memRdata;
  logic [7:0] mem [0:2047];

  int checks = 0, fails = 0;
  int doneCnt = 0, missCnt = 0, irqCnt = 0;

  always #10 clk = ~clk;

  rxring_top #(.AW(AW), .BUF_BYTES(BUF)) u0 (
    .clk(clk), .rstN(rstN), .stopped(stopped), .intEnable(intEnable),
    .ringBase(AW'(RING)), .bufBase(AW'(BUFB)), .rxValid(rxValid), .rxData(rxData),
    .rxLast(rxLast), .rxReady(rxReady), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .rxDone(rxDone), .rxMiss(rxMiss), .rxIrq(rxIrq)
  );

  always @(posedge clk) begin
    if (memEn && memWe) mem[memAddr[10:0]] <= memWdata;
    if (memEn && !memWe) memRdata <= mem[memAddr[10:0]];
  end

  always @(negedge clk) begin
    if (rxDone) doneCnt++;
    if (rxMiss) missCnt++;
    if (rxIrq)  irqCnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int dsc(input int i); return RING + 8*i; endfunction
  function automatic int bfa(input int i); return BUFB + BUF*i; endfunction

  task automatic sendFrame(input int len, input int seed);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rxValid = 1'b1; rxData = 8'(seed + k); rxLast = (k == len - 1);
      while (!rxReady) @(negedge clk);
    end
    @(negedge clk);
    rxValid = 1'b0; rxLast = 1'b0;
    repeat (120) @(negedge clk);
  endtask

  function automatic int msgLen(input int i);
    return {mem[dsc(i)+7], mem[dsc(i)+6]};
  endfunction

  task automatic tReset();
    @(negedge clk);
    chk(!rxReady && !rxDone && !rxMiss && !rxIrq, "R1 outputs idle", 0, 0);
  endtask

  task automatic tBasic();
    int d0, i0, bad;
    d0 = doneCnt; i0 = irqCnt; bad = 0;
    mem[dsc(0)+2] = 8'h80;
    sendFrame(64, 8'h10);
    for (int k = 0; k < 64; k++) if (mem[bfa(0)+k] != 8'(8'h10 + k)) bad++;
    chk(bad == 0, "R4 data bytes entry0", bad, 0);
    chk(msgLen(0) == 64, "R2 msg length entry0", msgLen(0), 64);
    chk(mem[dsc(0)+2] == 8'h03, "R7 status entry0", mem[dsc(0)+2], 8'h03);
    chk(doneCnt - d0 == 1, "R7 one done pulse", doneCnt - d0, 1);
    chk(irqCnt - i0 == 1, "R8 irq with enable", irqCnt - i0, 1);
  endtask

  task automatic tSkip();
    mem[dsc(1)+2] = 8'h00;
    mem[dsc(2)+2] = 8'h81;
    mem[dsc(3)+2] = 8'h80;
    mem[dsc(2)+6] = 8'hAA;
    sendFrame(61, 8'h40);
    chk(mem[dsc(3)+2] == 8'h03, "R3 lands in entry3", mem[dsc(3)+2], 8'h03);
    chk(mem[dsc(2)+2] == 8'h81 && mem[dsc(2)+6] == 8'hAA, "R3 inexact owner untouched",
        mem[dsc(2)+2], 8'h81);
    chk(mem[dsc(1)+2] == 8'h00, "R3 host entry untouched", mem[dsc(1)+2], 0);
    chk(mem[bfa(3)] == 8'h40 && msgLen(3) == 61, "R4 entry3 contents", msgLen(3), 61);
  endtask

  task automatic tPad();
    int bad;
    bad = 0;
    for (int k = 0; k < BUF; k++) mem[bfa(4)+k] = 8'hFF;
    mem[dsc(4)+2] = 8'h80;
    sendFrame(20, 8'h01);
    for (int k = 20; k < 60; k++) if (mem[bfa(4)+k] != 8'h00) bad++;
    chk(bad == 0, "R5 zero padding", bad, 0);
    chk(mem[bfa(4)+60] == 8'hFF, "R5 pad stops at 60", mem[bfa(4)+60], 8'hFF);
    chk(mem[bfa(4)+19] == 8'h14, "R5 last real byte", mem[bfa(4)+19], 8'h14);
    chk(msgLen(4) == 60, "R5 length 60", msgLen(4), 60);
  endtask

  task automatic tOverflow();
    int d0, i0;
    d0 = doneCnt; i0 = irqCnt;
    intEnable = 1'b0;
    mem[bfa(6)] = 8'h5A;
    mem[dsc(5)+2] = 8'h80;
    sendFrame(90, 8'h00);
    chk(msgLen(5) == BUF, "R6 truncated length", msgLen(5), BUF);
    chk(mem[dsc(5)+2] == 8'h53, "R6 overflow status", mem[dsc(5)+2], 8'h53);
    chk(mem[bfa(6)] == 8'h5A, "R6 no write past buffer", mem[bfa(6)], 8'h5A);
    chk(mem[bfa(5)+BUF-1] == 8'(BUF-1), "R6 last kept byte", mem[bfa(5)+BUF-1], BUF-1);
    chk(doneCnt - d0 == 1 && irqCnt == i0, "R8 no irq when disabled", irqCnt - i0, 0);
    intEnable = 1'b1;
  endtask

  task automatic tStopped();
    int d0;
    d0 = doneCnt;
    stopped = 1'b1;
    mem[dsc(6)+2] = 8'h80;
    sendFrame(30, 8'h77);
    chk(mem[dsc(6)+2] == 8'h80, "R9 descriptor kept", mem[dsc(6)+2], 8'h80);
    chk(mem[bfa(6)] == 8'h5A, "R9 buffer untouched", mem[bfa(6)], 8'h5A);
    chk(doneCnt == d0, "R9 no done", doneCnt - d0, 0);
    stopped = 1'b0;
  endtask

  task automatic tMiss();
    int d0, m0;
    d0 = doneCnt; m0 = missCnt;
    for (int i = 0; i < 16; i++) mem[dsc(i)+2] = 8'h00;
    sendFrame(40, 8'h22);
    chk(missCnt - m0 == 1, "R10 miss pulse", missCnt - m0, 1);
    chk(doneCnt == d0, "R10 no done", doneCnt - d0, 0);
    chk(mem[bfa(6)] == 8'h5A, "R10 no write", mem[bfa(6)], 8'h5A);
  endtask

  task automatic tWrap();
    mem[dsc(15)+2] = 8'h80;
    mem[dsc(0)+2]  = 8'h80;
    mem[dsc(5)+2]  = 8'h80;
    sendFrame(60, 8'h90);
    chk(mem[dsc(15)+2] == 8'h03, "R10 index kept after miss", mem[dsc(15)+2], 8'h03);
    chk(mem[dsc(0)+2] == 8'h80, "R3 search order", mem[dsc(0)+2], 8'h80);
    sendFrame(60, 8'hA0);
    chk(mem[dsc(0)+2] == 8'h03, "R7 index wraps to 0", mem[dsc(0)+2], 8'h03);
    chk(mem[bfa(0)] == 8'hA0 && mem[dsc(5)+2] == 8'h80, "R2 wrap buffer", mem[bfa(0)], 8'hA0);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    for (int a = 0; a < 2048; a++) mem[a] = 8'h00;
    memRdata = 8'h00;
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBasic();
    tSkip();
    tPad();
    tOverflow();
    tStopped();
    tMiss();
    tWrap();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finishRun();
  end
endmodule